// File: doc/BRIEF.md
# Event Performance Counter Bank

A cluster peripheral holding sixteen 32-bit event counters that software drives through a plain register bus. Each counter has an event-type mask, a hart mask and a count register. On every clock edge it adds up the enabled events it sees. A per-hart event adds one for each selected hart that raises it. A cluster-wide event adds one whatever the hart mask holds.

Software starts a counter by setting one bit in its event mask at the ordinal of the wanted event type. It stops the counter by clearing that mask, and the count stays where it was. A reset from software is three writes of zero: event mask, hart mask and count. There are 31 event types, in this order:

- 0: cycles.
- 1 to 9, per hart: local memory accessed, local memory congested, FPU issue, FPU sequencer issue, core-to-FPU issue, retired instructions, retired loads, retired integer operations, retired accelerator operations.
- 10 to 30, cluster-wide: DMA stalls (AW, AR, R, W, buffer W, buffer R), DMA AW done and bandwidth, AR done and bandwidth, R done and bandwidth, W done and bandwidth, B done, DMA busy, then instruction-cache miss, hit, prefetch, double hit and stall.

Top module: `perf_counter_bank`

## Requirements
- R1: The bank holds 16 counters, and each register takes an 8-byte slot. Event masks sit at byte offset 0x000 + 8·k, hart masks at 0x080 + 8·k and counts at 0x100 + 8·k. Byte address bits [6:3] give the counter index k and bits [8:7] give the array. Address bits above bit 8 must be zero.
- R2: A read request is answered in the next cycle. bus_rvalid_o is high for exactly that cycle, and bus_rdata_o holds the register value as it stood at the request edge. bus_rvalid_o stays low in any cycle that does not follow a read request.
- R3: Bit n of an event mask enables event type n. An event whose bit is clear adds nothing. An event mask of zero halts the counter, and the count is kept.
- R4: Per-hart types 1 to 9 use input hart_evt_i[h][n-1]. Each cycle they add the number of harts h whose hart-mask bit is set and whose input is high.
- R5: Cluster-wide types use input glob_evt_i. Type 0 uses bit 0 and type n ≥ 10 uses bit n-9. Each of these adds 1 in a cycle where its input is high, whatever the hart mask holds.
- R6: When several event bits are set, the increment is the sum of their contributions.
- R7: Counts wrap modulo 2^32 and do not saturate.
- R8: A write to a count register takes effect at the next edge. The increment for that cycle is dropped.
- R9: A hart mask keeps 8 bits, and an event mask keeps 31 bits. Bits above those read as zero.
- R10: Some offsets are unmapped: array field 3, the upper word of any slot (address bit 2 set), and any nonzero bit above bit 8. Reads of these return zero and writes to them change nothing.
- R11: Reset clears every mask and count, and clears bus_rvalid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read response strobe |
| hart_evt_i | input | 8x9 | Per-hart event strobes, [hart][type-1] |
| glob_evt_i | input | 22 | Cluster-wide event strobes |

## Verification
The hardest case to reach from the ports is a count write that lands on the same edge as a live increment. The bench holds the cycle event high through the write cycle and drops it at the very next falling edge. The read-back value then shows whether the write beat the add. Wrap-around is reached by preloading a count just below 2^32 and not by waiting. Several-hart sums are reached by driving all harts while only some are selected.

// File: rtl/perf_bank_pkg.sv
package perf_bank_pkg;

    localparam int EVT_TYPES = 31;
    localparam int PH_FIRST  = 1;
    localparam int PH_NUM    = 9;
    localparam int GL_NUM    = EVT_TYPES - PH_NUM;

    typedef enum logic [1:0] {
        ARR_EVT  = 2'd0,
        ARR_HART = 2'd1,
        ARR_CNT  = 2'd2,
        ARR_NONE = 2'd3
    } arr_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RESP = 1'b1
    } bus_st_e;

endpackage

// File: rtl/perf_addr_decode.sv
module perf_addr_decode
    import perf_bank_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SLOT_W = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    output arr_e              arr_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              map_ok_o
);
    localparam int MAP_W = SLOT_W + 5;

    logic upper_clear;

    generate
        if (ADDR_W > MAP_W) begin : g_upper
            assign upper_clear = (addr_i[ADDR_W-1:MAP_W] == '0);
        end else begin : g_no_upper
            assign upper_clear = 1'b1;
        end
    endgenerate

    assign arr_o    = arr_e'(addr_i[MAP_W-1:MAP_W-2]);
    assign slot_o   = addr_i[SLOT_W+2:3];
    assign map_ok_o = upper_clear && !addr_i[2] && (arr_o != ARR_NONE);

endmodule

// File: rtl/perf_evt_sum.sv
module perf_evt_sum
    import perf_bank_pkg::*;
#(
    parameter int NUM_HART = 8,
    parameter int INC_W    = 7
) (
    input  logic [EVT_TYPES-1:0]             en_i,
    input  logic [NUM_HART-1:0]              sel_i,
    input  logic [NUM_HART-1:0][PH_NUM-1:0]  hart_evt_i,
    input  logic [GL_NUM-1:0]                glob_evt_i,
    output logic [INC_W-1:0]                 inc_o
);
    logic [EVT_TYPES-1:0][INC_W-1:0] contrib;

    generate
        for (genvar t = 0; t < EVT_TYPES; t++) begin : g_type
            if (t >= PH_FIRST && t < PH_FIRST + PH_NUM) begin : g_hart
                logic [NUM_HART-1:0] hit;
                for (genvar h = 0; h < NUM_HART; h++) begin : g_h
                    assign hit[h] = sel_i[h] & hart_evt_i[h][t-PH_FIRST];
                end
                assign contrib[t] = en_i[t] ? INC_W'($countones(hit)) : '0;
            end else begin : g_glob
                localparam int GI = (t < PH_FIRST) ? t : t - PH_NUM;
                assign contrib[t] = (en_i[t] && glob_evt_i[GI]) ?
                                    {{(INC_W-1){1'b0}}, 1'b1} : '0;
            end
        end
    endgenerate

    always_comb begin
        inc_o = '0;
        for (int t = 0; t < EVT_TYPES; t++) begin
            inc_o = inc_o + contrib[t];
        end
    end

endmodule

// File: rtl/perf_cnt_slot.sv
module perf_cnt_slot
    import perf_bank_pkg::*;
#(
    parameter int NUM_HART = 8,
    parameter int CNT_W    = 32,
    parameter int DATA_W   = 32
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             wr_evt_i,
    input  logic                             wr_hart_i,
    input  logic                             wr_cnt_i,
    input  logic [DATA_W-1:0]                wdata_i,
    input  logic [NUM_HART-1:0][PH_NUM-1:0]  hart_evt_i,
    input  logic [GL_NUM-1:0]                glob_evt_i,
    output logic [EVT_TYPES-1:0]             en_o,
    output logic [NUM_HART-1:0]              sel_o,
    output logic [CNT_W-1:0]                 cnt_o
);
    localparam int INC_W = $clog2(PH_NUM * NUM_HART + GL_NUM + 1);

    logic [INC_W-1:0] inc;

    perf_evt_sum #(
        .NUM_HART (NUM_HART),
        .INC_W    (INC_W)
    ) u_sum (
        .en_i       (en_o),
        .sel_i      (sel_o),
        .hart_evt_i (hart_evt_i),
        .glob_evt_i (glob_evt_i),
        .inc_o      (inc)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_o  <= '0;
            sel_o <= '0;
            cnt_o <= '0;
        end else begin
            if (wr_evt_i) begin
                en_o <= wdata_i[EVT_TYPES-1:0];
            end
            if (wr_hart_i) begin
                sel_o <= wdata_i[NUM_HART-1:0];
            end
            if (wr_cnt_i) begin
                cnt_o <= wdata_i[CNT_W-1:0];
            end else begin
                cnt_o <= cnt_o + CNT_W'(inc);
            end
        end
    end

endmodule

// File: rtl/perf_bus_fsm.sv
module perf_bus_fsm
    import perf_bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_req_i,
    input  logic [DATA_W-1:0] rd_val_i,
    output logic              rvalid_o,
    output logic [DATA_W-1:0] rdata_o
);
    bus_st_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: state_d = rd_req_i ? S_RESP : S_IDLE;
            S_RESP: state_d = rd_req_i ? S_RESP : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            S_IDLE: rvalid_o = 1'b0;
            S_RESP: rvalid_o = 1'b1;
            default: rvalid_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_o <= '0;
        end else if (rd_req_i) begin
            rdata_o <= rd_val_i;
        end
    end

endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
    import perf_bank_pkg::*;
#(
    parameter int NUM_CNT  = 16,
    parameter int NUM_HART = 8,
    parameter int CNT_W    = 32,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 12
) (
    input  logic                                         clk_i,
    input  logic                                         rst_ni,
    input  logic                                         bus_req_i,
    input  logic                                         bus_we_i,
    input  logic [ADDR_W-1:0]                            bus_addr_i,
    input  logic [DATA_W-1:0]                            bus_wdata_i,
    output logic [DATA_W-1:0]                            bus_rdata_o,
    output logic                                         bus_rvalid_o,
    input  logic [NUM_HART-1:0][perf_bank_pkg::PH_NUM-1:0] hart_evt_i,
    input  logic [perf_bank_pkg::GL_NUM-1:0]             glob_evt_i
);
    localparam int SLOT_W = $clog2(NUM_CNT);

    arr_e              arr;
    logic [SLOT_W-1:0] slot;
    logic              map_ok;
    logic              wr_acc;
    logic              rd_acc;
    logic [DATA_W-1:0] rd_val;

    logic [NUM_CNT-1:0][EVT_TYPES-1:0] en_all;
    logic [NUM_CNT-1:0][NUM_HART-1:0]  sel_all;
    logic [NUM_CNT-1:0][CNT_W-1:0]     cnt_all;

    perf_addr_decode #(
        .ADDR_W (ADDR_W),
        .SLOT_W (SLOT_W)
    ) u_dec (
        .addr_i   (bus_addr_i),
        .arr_o    (arr),
        .slot_o   (slot),
        .map_ok_o (map_ok)
    );

    assign wr_acc = bus_req_i && bus_we_i && map_ok;
    assign rd_acc = bus_req_i && !bus_we_i;

    generate
        for (genvar k = 0; k < NUM_CNT; k++) begin : g_slot
            logic hit;
            assign hit = wr_acc && (slot == SLOT_W'(k));

            perf_cnt_slot #(
                .NUM_HART (NUM_HART),
                .CNT_W    (CNT_W),
                .DATA_W   (DATA_W)
            ) u_slot (
                .clk_i      (clk_i),
                .rst_ni     (rst_ni),
                .wr_evt_i   (hit && (arr == ARR_EVT)),
                .wr_hart_i  (hit && (arr == ARR_HART)),
                .wr_cnt_i   (hit && (arr == ARR_CNT)),
                .wdata_i    (bus_wdata_i),
                .hart_evt_i (hart_evt_i),
                .glob_evt_i (glob_evt_i),
                .en_o       (en_all[k]),
                .sel_o      (sel_all[k]),
                .cnt_o      (cnt_all[k])
            );
        end
    endgenerate

    always_comb begin
        rd_val = '0;
        if (map_ok) begin
            case (arr)
                ARR_EVT:  rd_val = DATA_W'(en_all[slot]);
                ARR_HART: rd_val = DATA_W'(sel_all[slot]);
                ARR_CNT:  rd_val = DATA_W'(cnt_all[slot]);
                default:  rd_val = '0;
            endcase
        end
    end

    perf_bus_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .rd_req_i (rd_acc),
        .rd_val_i (rd_val),
        .rvalid_o (bus_rvalid_o),
        .rdata_o  (bus_rdata_o)
    );

endmodule

// File: rtl/perf_counter_bank_chk.sv
module perf_counter_bank_chk #(
    parameter int NUM_CNT  = 16,
    parameter int NUM_HART = 8,
    parameter int CNT_W    = 32,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 12,
    parameter int EVT_N    = 31
) (
    input logic                              clk_i,
    input logic                              rst_ni,
    input logic                              req,
    input logic                              we,
    input logic [ADDR_W-1:0]                 addr,
    input logic [DATA_W-1:0]                 wdata,
    input logic [DATA_W-1:0]                 rdata,
    input logic                              rvalid,
    input logic [NUM_CNT-1:0][EVT_N-1:0]     en_all,
    input logic [NUM_CNT-1:0][CNT_W-1:0]     cnt_all
);
    localparam int SLOT_W = $clog2(NUM_CNT);
    localparam int MAP_W  = SLOT_W + 5;

    logic [1:0] arr_f;
    logic       rd_now;
    assign arr_f  = addr[MAP_W-1:MAP_W-2];
    assign rd_now = req && !we;

    // R2: a read request is answered on the following cycle
    p_read_resp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_now |=> rvalid);

    // R2: no response without a request
    p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_now |=> !rvalid);

    // R10: unmapped reads return zero
    p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_now && (addr[2] || arr_f == 2'd3)) |=> (rdata == '0));

    generate
        if (NUM_HART < DATA_W) begin : g_sel_top
            // R9: hart mask bits above the hart count read zero
            p_sel_upper_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (rd_now && !addr[2] && arr_f == 2'd1) |=> (rdata[DATA_W-1:NUM_HART] == '0));
        end

        for (genvar k = 0; k < NUM_CNT; k++) begin : g_k
            logic wr_k;
            assign wr_k = req && we && !addr[2] && (arr_f == 2'd2) &&
                          (addr[SLOT_W+2:3] == SLOT_W'(k)) &&
                          ((ADDR_W > MAP_W) ? ((addr >> MAP_W) == '0) : 1'b1);

            // R3: a counter with an empty event mask keeps its count
            p_hold_when_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
                ((en_all[k] == '0) && !wr_k) |=> (cnt_all[k] == $past(cnt_all[k])));

            // R8: a count write wins over a same-cycle increment
            p_cnt_write_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                wr_k |=> (cnt_all[k] == $past(wdata[CNT_W-1:0])));
        end
    endgenerate

endmodule

bind perf_counter_bank perf_counter_bank_chk #(
    .NUM_CNT  (NUM_CNT),
    .NUM_HART (NUM_HART),
    .CNT_W    (CNT_W),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .EVT_N    (perf_bank_pkg::EVT_TYPES)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req     (bus_req_i),
    .we      (bus_we_i),
    .addr    (bus_addr_i),
    .wdata   (bus_wdata_i),
    .rdata   (bus_rdata_o),
    .rvalid  (bus_rvalid_o),
    .en_all  (en_all),
    .cnt_all (cnt_all)
);

// File: tb/test_perf_counter_bank.sv
module test_perf_counter_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NH = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req = 1'b0;
    logic             we = 1'b0;
    logic [11:0]      addr = '0;
    logic [31:0]      wdata = '0;
    logic [31:0]      rdata;
    logic             rvalid;
    logic [NH-1:0][8:0] hart_evt = '0;
    logic [21:0]      glob_evt = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    perf_counter_bank i_perf_counter_bank (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .bus_req_i    (req),
        .bus_we_i     (we),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .bus_rvalid_o (rvalid),
        .hart_evt_i   (hart_evt),
        .glob_evt_i   (glob_evt)
    );

    function automatic logic [11:0] a_evt(int k);  return 12'(k*8);         endfunction
    function automatic logic [11:0] a_hart(int k); return 12'(12'h080 + k*8); endfunction
    function automatic logic [11:0] a_cnt(int k);  return 12'(12'h100 + k*8); endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        req = 1'b1; we = 1'b0; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, e);
        end
    endtask

    // monitor: pops the scoreboard on every read response
    always @(negedge clk) begin
        if (rst_n && rvalid && !done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected response", rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rdata === e, t, rdata, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        check(rvalid === 1'b0, "R11 rvalid in reset", 32'(rvalid), 32'h0);
        rst_n = 1'b1;
        idle(2);

        // R11: reset state
        rd(a_evt(0),  32'h0, "R11 event mask after reset");
        rd(a_hart(0), 32'h0, "R11 hart mask after reset");
        rd(a_cnt(15), 32'h0, "R11 count after reset");

        // R9: register widths
        wr(a_hart(3), 32'hFFFF_FFFF);
        wr(a_evt(3),  32'hFFFF_FFFF);
        rd(a_hart(3), 32'h0000_00FF, "R9 hart mask width");
        rd(a_evt(3),  32'h7FFF_FFFF, "R9 event mask width");
        wr(a_evt(3), 32'h0);
        wr(a_hart(3), 32'h0);
        wr(a_cnt(3), 32'h0);

        // R4: retired instructions (type 6), harts 0 and 2 selected
        wr(a_hart(1), 32'h0000_0005);
        wr(a_evt(1),  32'h1 << 6);
        for (int h = 0; h < NH; h++) hart_evt[h][5] = 1'b1;
        idle(4);
        for (int h = 0; h < NH; h++) hart_evt[h][5] = 1'b0;
        hart_evt[1][5] = 1'b1;
        idle(3);
        hart_evt[1][5] = 1'b0;
        rd(a_cnt(1), 32'd8, "R4 per-hart sum over selected harts");

        // R5: cycles (type 0) and DMA R done (type 20 -> glob bit 11), empty hart mask
        wr(a_evt(2), 32'h1);
        wr(a_evt(4), 32'h1 << 20);
        glob_evt[0] = 1'b1;
        idle(5);
        glob_evt[0] = 1'b0;
        glob_evt[11] = 1'b1;
        idle(3);
        glob_evt[11] = 1'b0;
        rd(a_cnt(2), 32'd5, "R5 cycle event ignores hart mask");
        rd(a_cnt(4), 32'd3, "R5 cluster-wide DMA event");

        // R3: stopping keeps the count; unselected type adds nothing
        wr(a_evt(2), 32'h0);
        wr(a_evt(5), 32'h1 << 27);
        glob_evt[0] = 1'b1;
        glob_evt[17] = 1'b1;
        idle(4);
        glob_evt[0] = 1'b0;
        glob_evt[17] = 1'b0;
        rd(a_cnt(2), 32'd5, "R3 halted counter keeps count");
        rd(a_cnt(5), 32'd0, "R3 disabled type adds nothing");
        glob_evt[18] = 1'b1;
        idle(2);
        glob_evt[18] = 1'b0;
        rd(a_cnt(5), 32'd2, "R3 enabled type 27 counts");

        // R6: two enabled types sum (cycles + memory accessed on all 8 harts)
        wr(a_hart(6), 32'h0000_00FF);
        wr(a_evt(6),  32'h3);
        glob_evt[0] = 1'b1;
        for (int h = 0; h < NH; h++) hart_evt[h][0] = 1'b1;
        idle(2);
        glob_evt[0] = 1'b0;
        for (int h = 0; h < NH; h++) hart_evt[h][0] = 1'b0;
        rd(a_cnt(6), 32'd18, "R6 multiple enabled types sum");

        // R7: wrap modulo 2^32
        wr(a_cnt(7), 32'hFFFF_FFFE);
        wr(a_evt(7), 32'h1);
        glob_evt[0] = 1'b1;
        idle(3);
        glob_evt[0] = 1'b0;
        rd(a_cnt(7), 32'h0000_0001, "R7 wrap");

        // R8: count write on a cycle with a live increment
        wr(a_evt(8), 32'h1);
        glob_evt[0] = 1'b1;
        idle(2);
        wr(a_cnt(8), 32'd100);
        glob_evt[0] = 1'b0;
        rd(a_cnt(8), 32'd100, "R8 write beats increment");

        // R10: unmapped accesses
        wr(12'h04C, 32'h0000_0001);
        wr(12'h1C0, 32'hFFFF_FFFF);
        wr(12'h248, 32'h0000_0001);
        wr(12'h24C, 32'h1234_5678);
        rd(a_evt(9), 32'h0, "R10 upper-word write ignored");
        rd(12'h04C,  32'h0, "R10 upper word reads zero");
        rd(12'h1C0,  32'h0, "R10 array 3 reads zero");
        rd(12'h34C,  32'h0, "R10 high address bits read zero");
        rd(a_cnt(9), 32'h0, "R10 high address write ignored");

        // R1: every count slot maps to its own register
        for (int k = 10; k < 16; k++) wr(a_cnt(k), 32'hA5A5_0000 + 32'(k));
        wr(a_evt(15), 32'h0000_0400);
        for (int k = 10; k < 16; k++) rd(a_cnt(k), 32'hA5A5_0000 + 32'(k), "R1 count slot map");
        rd(a_evt(15), 32'h0000_0400, "R1 event mask slot 15");
        rd(a_cnt(1),  32'd8, "R1 slot 1 untouched");

        idle(2);
        check(rvalid === 1'b0, "R2 rvalid low when idle", 32'(rvalid), 32'h0);
        check(exp_q.size() == 0, "R2 all reads answered", 32'(exp_q.size()), 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule